// File: doc/BRIEF.md
# Noise-Shaped Phase Sine Synthesizer

This block produces a digital sine wave whose frequency is set by a tuning word. Every enabled clock a 16-bit phase register advances by the tuning word and wraps around the phase circle. The top 12 bits of that phase are then reduced to an 8-bit table address. This is not done by simply dropping bits. A fourth-order error-feedback loop pushes the reduction error up to high frequencies, where a reconstruction filter downstream can remove it. A quarter-wave sine table, built at elaboration from an integer series, turns the address into a signed 12-bit amplitude.

A host holds `enable` high and writes `tuneWord`. Samples then appear three clocks later with `sampleValid` set. The tuning word can be changed at any time. The phase register is never reloaded, so the waveform continues without a phase step. When `enable` is low the whole pipeline freezes and the last sample is held.

Top module: `shaped_phase_synth`

## Requirements
- R1: While reset is asserted and after it is released, `sampleValid` is 0 and `sampleOut` is 0 until the first sample arrives. Reset clears the phase register and all shaper error history, so with `tuneWord` = 0 the first sample after reset equals the table value for address 0.
- R2: The phase register is 16 bits wide. It adds `tuneWord` at every rising edge where `enable` is 1 and wraps modulo 65536. With `tuneWord` = 0x8000 from phase 0, the addresses alternate between 128 and 0.
- R3: A tuning word applied with `enable` high before edge k produces a valid sample after edge k+2. `sampleValid` is 1 exactly when `enable` was 1 three rising edges earlier.
- R4: `sampleOut` is two's complement. For address a it is within 1 LSB of round(2047·sin(2π(a+0.5)/256)), it never takes the value -2048, and the sample for address a+128 is the negation of the sample for address a.
- R5: The shaper input is u = phase[15:4]. Each step it forms s = (u + 4·e1 − 6·e2 + 4·e3 − e4) mod 4096, where e1 is the most recent residual. The table address is s[11:4] and the new residual is s[3:0]. So 16·address − u always lies within ±120 modulo 4096.
- R6: A new `tuneWord` is used from the next enabled edge on. The phase register keeps its value across the change.
- R7: While `enable` is 0 the phase register, the shaper history and `sampleOut` all hold. `sampleValid` falls on the third edge after the last enabled edge. Accumulation resumes from the held phase.
- R8: With `tuneWord` = 0 after reset, every sample equals the table value for address 0, which is 25.
- R9: The shaped sum folds modulo 4096, so an address that would pass 255 wraps to the start of the phase circle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advances the phase register and the pipeline |
| tuneWord | input | 16 | Frequency tuning word added to the phase each enabled clock |
| sampleOut | output | 12 | Signed sine amplitude |
| sampleValid | output | 1 | Marks a sample produced from an enabled phase step |

## Verification
Some rules are checked on every cycle. These are the phase step and its wrap, the phase hold while disabled, and the three-clock origin of `sampleValid`. Also checked each cycle: the sample is held whenever it is not valid, the sample never takes the forbidden negative extreme, and the shaped address stays within ±120 of the truncated phase. The exact address sequence produced by the fourth-order error feedback cannot be checked this way, and neither can the sine values or the quadrant symmetry. The bench shows these through its scenarios. It compares every sample against an independent arithmetic model of the requirements and a floating-point sine. Its directed cases also cover the latency after reset, half-circle wrap alternation, tuning changes and freeze/resume.

// File: rtl/synth_pkg.sv
package synth_pkg;

  typedef struct packed {
    logic accStep;
    logic shapeStep;
    logic romStep;
    logic outValid;
  } synthStb_t;

  // Signed coefficient of the k-th delayed residual for an order-N
  // (1 - z^-1)^N error-feedback loop: +C(N,k) for odd k, -C(N,k) for even k.
  function automatic int shaperCoef(input int order, input int k);
    int c;
    c = 1;
    for (int j = 0; j < k; j++) begin
      c = c * (order - j) / (j + 1);
    end
    return ((k % 2) == 1) ? c : -c;
  endfunction

endpackage

// File: rtl/synth_ctrl.sv
module synth_ctrl
  import synth_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  output synthStb_t stb
);

  logic stage1Q;
  logic stage2Q;
  logic stage3Q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
      stage3Q <= 1'b0;
    end else begin
      stage1Q <= enable;
      stage2Q <= stage1Q;
      stage3Q <= stage2Q;
    end
  end

  always_comb begin
    stb.accStep   = enable;
    stb.shapeStep = stage1Q;
    stb.romStep   = stage2Q;
    stb.outValid  = stage3Q;
  end

endmodule

// File: rtl/synth_noise_shaper.sv
module synth_noise_shaper
  import synth_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8,
  parameter int ORDER = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [IN_W-1:0]  phaseIn,
  output logic [OUT_W-1:0] addrOut
);

  localparam int RES_W = IN_W - OUT_W;

  logic [RES_W-1:0] errHist [ORDER];
  logic [IN_W-1:0]  sumWord;
  int               fbSum;

  always_comb begin
    fbSum = 0;
    for (int k = 0; k < ORDER; k++) begin
      fbSum = fbSum + shaperCoef(ORDER, k + 1) * int'(errHist[k]);
    end
    sumWord = phaseIn + IN_W'(fbSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrOut <= '0;
      for (int k = 0; k < ORDER; k++) begin
        errHist[k] <= '0;
      end
    end else if (step) begin
      addrOut    <= sumWord[IN_W-1 -: OUT_W];
      errHist[0] <= sumWord[RES_W-1:0];
      for (int k = 1; k < ORDER; k++) begin
        errHist[k] <= errHist[k-1];
      end
    end
  end

endmodule

// File: rtl/synth_sine_rom.sv
module synth_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] amp
);

  localparam int QTR_W     = ADDR_W - 2;
  localparam int QTR_DEPTH = 1 << QTR_W;
  localparam int AMP_MAX   = (1 << (AMP_W - 1)) - 1;
  localparam longint PI_Q30 = 64'sd3373259426;

  // sin(pi*(2i+1)/(4*QTR_DEPTH)) * AMP_MAX, by a fixed-point Taylor series
  function automatic int quarterAmp(input int i);
    longint x;
    longint term;
    longint sum;
    longint t;
    x    = (PI_Q30 * longint'(2 * i + 1)) / longint'(4 * QTR_DEPTH);
    term = x;
    sum  = x;
    for (int k = 1; k <= 7; k++) begin
      t    = (term * x) >>> 30;
      t    = (t * x) >>> 30;
      term = -(t / longint'((2 * k) * (2 * k + 1)));
      sum  = sum + term;
    end
    return int'((sum * longint'(AMP_MAX) + (64'sd1 <<< 29)) >>> 30);
  endfunction

  logic [AMP_W-2:0] qTab [QTR_DEPTH];

  for (genvar i = 0; i < QTR_DEPTH; i++) begin : g_qtab
    assign qTab[i] = (AMP_W-1)'(quarterAmp(i));
  end

  logic [1:0]              quadrant;
  logic [QTR_W-1:0]        qIdx;
  logic signed [AMP_W-1:0] magExt;

  always_comb begin
    quadrant = addr[ADDR_W-1 -: 2];
    qIdx     = quadrant[0] ? ~addr[QTR_W-1:0] : addr[QTR_W-1:0];
    magExt   = {1'b0, qTab[qIdx]};
    amp      = quadrant[1] ? -magExt : magExt;
  end

endmodule

// File: rtl/synth_datapath.sv
module synth_datapath
  import synth_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int TRUNC_W = 12,
  parameter int ADDR_W  = 8,
  parameter int AMP_W   = 12,
  parameter int ORDER   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  synthStb_t        stb,
  input  logic [ACC_W-1:0] tuneWord,
  output logic [AMP_W-1:0] sampleOut
);

  localparam int CUT_W = ACC_W - TRUNC_W;

  logic [ACC_W-1:0]        phaseAcc;
  logic [ADDR_W-1:0]       romAddr;
  logic signed [AMP_W-1:0] romAmp;
  logic                    unusedLsbs;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
    end else if (stb.accStep) begin
      phaseAcc <= phaseAcc + tuneWord;
    end
  end

  assign unusedLsbs = ^phaseAcc[CUT_W-1:0];

  synth_noise_shaper #(
    .IN_W (TRUNC_W),
    .OUT_W(ADDR_W),
    .ORDER(ORDER)
  ) shaper_i (
    .clk    (clk),
    .rst    (rst),
    .step   (stb.shapeStep),
    .phaseIn(phaseAcc[ACC_W-1 -: TRUNC_W]),
    .addrOut(romAddr)
  );

  synth_sine_rom #(
    .ADDR_W(ADDR_W),
    .AMP_W (AMP_W)
  ) rom_i (
    .addr(romAddr),
    .amp (romAmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut <= '0;
    end else if (stb.romStep) begin
      sampleOut <= romAmp;
    end
  end

endmodule

// File: rtl/shaped_phase_synth.sv
module shaped_phase_synth
  import synth_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int TRUNC_W = 12,
  parameter int ADDR_W  = 8,
  parameter int AMP_W   = 12,
  parameter int ORDER   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [ACC_W-1:0] tuneWord,
  output logic [AMP_W-1:0] sampleOut,
  output logic             sampleValid
);

  synthStb_t stb;

  synth_ctrl ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .stb   (stb)
  );

  synth_datapath #(
    .ACC_W  (ACC_W),
    .TRUNC_W(TRUNC_W),
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W),
    .ORDER  (ORDER)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .tuneWord (tuneWord),
    .sampleOut(sampleOut)
  );

  assign sampleValid = stb.outValid;

endmodule

// File: rtl/shaped_phase_synth_chk.sv
module shaped_phase_synth_chk (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic [15:0] tuneWord,
  input logic [11:0] sampleOut,
  input logic        sampleValid,
  input logic [15:0] phaseAcc,
  input logic [7:0]  romAddr,
  input logic        shapeStep
);

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && $past(!rst)) |-> (phaseAcc == 16'($past(phaseAcc) + $past(tuneWord)))); // R2

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!enable) && $past(!rst)) |-> $stable(phaseAcc)); // R7

  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(enable, 3)); // R3

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> $stable(sampleOut)); // R7

  AST_AMP_RANGE: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (sampleOut != 12'h800)); // R4

  AST_SHAPE_BOUND: assert property (@(posedge clk) disable iff (rst)
    ($past(shapeStep) && $past(!rst)) |->
      ((12'({romAddr, 4'b0000} - $past(phaseAcc[15:4])) <= 12'd120) ||
       (12'({romAddr, 4'b0000} - $past(phaseAcc[15:4])) >= 12'd3976))); // R5

endmodule

bind shaped_phase_synth shaped_phase_synth_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .tuneWord   (tuneWord),
  .sampleOut  (sampleOut),
  .sampleValid(sampleValid),
  .phaseAcc   (dp_i.phaseAcc),
  .romAddr    (dp_i.romAddr),
  .shapeStep  (stb.shapeStep)
);

// File: tb/shaped_phase_synth_tb_top.sv
module shaped_phase_synth_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        en;
    logic [15:0] ftw;
    logic [15:0] cycles;
    logic [3:0]  tag;
  } segVec_t;

  localparam segVec_t SEGS [10] = '{
    '{1'b1, 16'h0123, 16'd40, 4'd5},
    '{1'b1, 16'h0FFF, 16'd30, 4'd6},
    '{1'b1, 16'hFFFF, 16'd30, 4'd9},
    '{1'b0, 16'h4000, 16'd8,  4'd7},
    '{1'b1, 16'h4000, 16'd20, 4'd6},
    '{1'b1, 16'h0001, 16'd60, 4'd5},
    '{1'b1, 16'h7FF7, 16'd25, 4'd9},
    '{1'b1, 16'hFFF3, 16'd40, 4'd9},
    '{1'b0, 16'h0000, 16'd5,  4'd7},
    '{1'b1, 16'h1357, 16'd40, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] tuneWord = 16'h0000;
  logic [11:0] sampleOut;
  logic        sampleValid;

  int    nChecks = 0;
  int    nFails = 0;
  bit    autoCheck = 1'b0;
  string segTag = "R5";

  // model of the requirements
  logic [15:0] mAcc = '0;
  logic [3:0]  mErr [4] = '{default: 4'h0};
  logic [7:0]  mAddr = '0;
  logic [7:0]  mOutAddr = '0;
  bit          mV1 = 0, mV2 = 0, mV3 = 0, mLoaded = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shaped_phase_synth dut_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tuneWord   (tuneWord),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

  function automatic int expAmp(input int a);
    real ang;
    ang = 2.0 * 3.14159265358979 * (real'(a) + 0.5) / 256.0;
    return int'(2047.0 * $sin(ang));
  endfunction

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd9: return "R9";
      default: return "R5";
    endcase
  endfunction

  function automatic int sampleInt();
    return int'($signed(sampleOut));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkNear(input string tag, input int exp);
    int d;
    d = sampleInt() - exp;
    check((d <= 1) && (d >= -1), tag, sampleInt(), exp);
  endtask

  // R5 shaper arithmetic, R2 phase step, R3 pipeline, taken from the requirements
  always @(posedge clk) begin
    if (rst) begin
      mAcc = '0;
      for (int k = 0; k < 4; k++) mErr[k] = '0;
      mAddr = '0; mOutAddr = '0;
      mV1 = 0; mV2 = 0; mV3 = 0; mLoaded = 0;
    end else begin
      logic [11:0] u;
      logic [11:0] s;
      int fb;
      if (mV2) begin
        mOutAddr = mAddr;
        mLoaded  = 1;
      end
      if (mV1) begin
        u  = mAcc[15:4];
        fb = 4 * int'(mErr[0]) - 6 * int'(mErr[1]) + 4 * int'(mErr[2]) - int'(mErr[3]);
        s  = u + 12'(fb);
        mAddr   = s[11:4];
        mErr[3] = mErr[2];
        mErr[2] = mErr[1];
        mErr[1] = mErr[0];
        mErr[0] = s[3:0];
      end
      if (enable) mAcc = mAcc + tuneWord;
      mV3 = mV2;
      mV2 = mV1;
      mV1 = enable;
    end
  end

  always @(negedge clk) begin
    if (autoCheck && !rst) begin
      check(sampleValid == mV3, "R3", int'(sampleValid), int'(mV3));
      if (mLoaded) checkNear(segTag, expAmp(int'(mOutAddr)));
      else check(sampleOut == 12'h000, "R1", sampleInt(), 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(sampleValid == 1'b0, "R1", int'(sampleValid), 0);
    check(sampleOut == 12'h000, "R1", sampleInt(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sampleValid == 1'b0, "R1", int'(sampleValid), 0);

    // R3 latency and R8 constant phase
    enable = 1'b1; tuneWord = 16'h0000;
    @(negedge clk);
    check(sampleValid == 1'b0, "R3", int'(sampleValid), 0);
    @(negedge clk);
    check(sampleValid == 1'b0, "R3", int'(sampleValid), 0);
    @(negedge clk);
    check(sampleValid == 1'b1, "R3", int'(sampleValid), 1);
    check(sampleInt() == 25, "R8", sampleInt(), 25);
    @(negedge clk);
    check(sampleInt() == 25, "R8", sampleInt(), 25);

    // R2 half-circle wrap, R4 symmetry
    tuneWord = 16'h8000;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    checkNear("R2", expAmp(128));
    check(sampleInt() == -expAmp(0), "R4", sampleInt(), -expAmp(0));
    @(negedge clk);
    check(sampleInt() == expAmp(0), "R2", sampleInt(), expAmp(0));
    @(negedge clk);
    check(sampleInt() == -25, "R2", sampleInt(), -25);

    // vector walk against the model
    autoCheck = 1'b1;
    foreach (SEGS[i]) begin
      enable   = SEGS[i].en;
      tuneWord = SEGS[i].ftw;
      segTag   = tagName(SEGS[i].tag);
      repeat (int'(SEGS[i].cycles)) @(negedge clk);
    end

    // R7 freeze: output holds while disabled
    enable = 1'b0;
    repeat (4) @(negedge clk);
    held = sampleInt();
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check(sampleValid == 1'b0, "R7", int'(sampleValid), 0);
      check(sampleInt() == held, "R7", sampleInt(), held);
    end
    enable = 1'b1; tuneWord = 16'h0ABC; segTag = "R7";
    repeat (20) @(negedge clk);

    // R1 reset mid-run clears phase and shaper history
    autoCheck = 1'b0;
    rst = 1'b1; tuneWord = 16'h0000;
    repeat (2) @(negedge clk);
    check(sampleOut == 12'h000, "R1", sampleInt(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sampleValid == 1'b0, "R1", int'(sampleValid), 0);
    repeat (2) @(negedge clk);
    check(sampleValid == 1'b1, "R3", int'(sampleValid), 1);
    check(sampleInt() == 25, "R1", sampleInt(), 25);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule